// File: doc/BRIEF.md
# Single-Port Memory Delay Line

This block delays a continuous stream of W-bit samples by a fixed number of cycles, N. A new sample is taken on every clock edge and a delayed sample is presented on every cycle, with no valid or stall signalling. It suits alignment paths in pipelined signal processing, where a plain register chain would cost too much area and a dual-ported memory is not wanted.

Samples are stored in a memory with a single port. The memory holds N/2 words of 2W bits each. The port alternates between a read turn and a write turn. On a read turn, the incoming sample is held and the word for the current address is fetched. On the following write turn, the held sample and the new sample are stored together in that same location, and the address moves on. The fetched word feeds the output through a half-select, so its two samples appear on two consecutive cycles.

After a synchronous reset, locations that have not yet been rewritten read as zero. A reset applied in the middle of a stream therefore never lets earlier data reach the output.

Top module: `sp_delay_line`

## Requirements
- R1: For the first N clock edges after reset is released, `dout` is zero.
- R2: From edge N onward, `dout` after edge m equals the `din` value sampled at edge m−N. One sample enters and one leaves on every cycle.
- R3: Edges after reset are counted from 0. The sample taken on an even edge (older) and the sample taken on the following odd edge (newer) form one pair. The pair is stored as one 2W-bit word, with the older sample in bits [W−1:0] and the newer sample in bits [2W−1:W].
- R4: The memory port is never asked to read and write in the same cycle. After reset, read turns and write turns alternate strictly, beginning with a read.
- R5: One address serves N/2 locations. It stays in the range 0 to N/2−1 and wraps to 0. A write uses the same address as the read just before it, and the address advances only after a write.
- R6: A fetched word is shown as its low half in the cycle after the read and as its high half in the cycle after that. The fetched word does not change between those two cycles.
- R7: A synchronous reset applied mid-stream forces `dout` to zero while reset is held. After release, R1 applies again, and no sample stored before the reset appears at the output.
- R8: The block works for any even N of at least 4, including values where N/2 is not a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Input sample, taken on every rising edge |
| dout | output | W | Sample delayed by N cycles |

## Verification
The bench runs three delay lengths side by side on the same stream: 16, 4 (the shortest allowed), and 6 (a depth of three, so the wrap is not at a power of two). Together they expose an address that wraps at the wrong count, or a design that is off by one cycle and shows the whole stream shifted.

Runs of all ones, all zeros, alternating patterns and a counting ramp show swapped pair halves as neighbouring samples trading places. They also show a missing hold of the fetched word as a repeated or lost sample every other cycle.

A mid-stream reset, followed by checks through the zero-fill window, catches stale memory contents leaking out after reset. A design that reads after writing within a pass would return the current pair instead of the one stored N cycles earlier.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  // Turn of the single memory port in the coming cycle.
  typedef enum logic {
    TURN_READ  = 1'b0,
    TURN_WRITE = 1'b1
  } turn_e;

  // Address width for a memory of the given word count (at least one bit).
  function automatic int unsigned addr_bits(int unsigned words);
    return (words > 1) ? $clog2(words) : 1;
  endfunction

endpackage

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  output logic          rd_en,
  output logic          wr_en,
  output logic [AW-1:0] addr,
  output logic          blank
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  turn_e turn_q;
  logic  primed_q;

  // Port turn flips every cycle; the first cycle after reset is a read.
  always_ff @(posedge clk) begin
    if (rst) turn_q <= TURN_READ;
    else     turn_q <= (turn_q == TURN_READ) ? TURN_WRITE : TURN_READ;
  end

  assign rd_en = (turn_q == TURN_READ)  && !rst;
  assign wr_en = (turn_q == TURN_WRITE) && !rst;

  // One address per sample pair; it advances after the write of the pair.
  always_ff @(posedge clk) begin
    if (rst)        addr <= '0;
    else if (wr_en) addr <= (addr == LAST) ? '0 : addr + AW'(1);
  end

  // Every location has been written once after the last write of pass one.
  always_ff @(posedge clk) begin
    if (rst)                         primed_q <= 1'b0;
    else if (wr_en && addr == LAST)  primed_q <= 1'b1;
  end

  assign blank = !primed_q;

  assert_port_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> wr_en);

  assert_write_then_read_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_en);

  assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST);

  assert_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (addr == $past(addr)));

endmodule

// File: rtl/sdl_pack.sv
module sdl_pack #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [W-1:0]   din,
  output logic [2*W-1:0] wdata
);

  logic [W-1:0] older_q;

  // The older sample of a pair arrives on the read turn and waits one cycle.
  always_ff @(posedge clk) begin
    if (rst)        older_q <= '0;
    else if (rd_en) older_q <= din;
  end

  assign wdata = {din, older_q};

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wdata[W-1:0] == $past(din)) && (wdata[2*W-1:W] == din));

endmodule

// File: rtl/sdl_spram.sv
module sdl_spram #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          blank,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Single port: write turn.
  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // Single port: read turn, registered output. Unwritten words read as zero.
  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= blank ? '0 : mem[addr];
  end

endmodule

// File: rtl/sdl_unpack.sv
module sdl_unpack #(
  parameter int unsigned W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           show_hi,
  input  logic [2*W-1:0] word,
  output logic [W-1:0]   dout
);

  assign dout = show_hi ? word[2*W-1:W] : word[W-1:0];

  assert_hold_pair_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(show_hi) && !$past(rst)) |-> $stable(word));

endmodule

// File: rtl/sp_delay_line.sv
module sp_delay_line
  import sdl_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int unsigned DEPTH = N / 2;
  localparam int unsigned AW    = addr_bits(DEPTH);
  localparam int unsigned ZW    = $clog2(N + 2);

  logic           rd_en;
  logic           wr_en;
  logic           blank;
  logic [AW-1:0]  addr;
  logic [2*W-1:0] wdata;
  logic [2*W-1:0] rword;

  sdl_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .blank (blank)
  );

  sdl_pack #(.W(W)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .din   (din),
    .wdata (wdata)
  );

  sdl_spram #(.DW(2*W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .blank (blank),
    .rdata (rword)
  );

  // After a write turn the high half is due; after a read turn the low half.
  sdl_unpack #(.W(W)) u_unpack (
    .clk     (clk),
    .rst     (rst),
    .show_hi (rd_en),
    .word    (rword),
    .dout    (dout)
  );

  // Counts edges since reset release, saturating one past N.
  logic [ZW-1:0] since_rst_q;
  always_ff @(posedge clk) begin
    if (rst)                             since_rst_q <= '0;
    else if (since_rst_q != ZW'(N + 1))  since_rst_q <= since_rst_q + ZW'(1);
  end

  assert_zero_fill_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst_q <= ZW'(N)) |-> (dout == '0));

endmodule

// File: tb/sp_delay_line_test.sv
module sp_delay_line_test;

  localparam int BW = 8;
  localparam int HN = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [BW-1:0] din = '0;
  logic [BW-1:0] dout16, dout4, dout6;

  always #5 clk = ~clk;

  sp_delay_line #(.W(BW), .N(16)) uut    (.clk(clk), .rst(rst), .din(din), .dout(dout16));
  sp_delay_line #(.W(BW), .N(4))  uut_n4 (.clk(clk), .rst(rst), .din(din), .dout(dout4));
  sp_delay_line #(.W(BW), .N(6))  uut_n6 (.clk(clk), .rst(rst), .din(din), .dout(dout6));

  int checks = 0;
  int fails  = 0;
  int m      = 0;
  bit after_mid = 1'b0;
  logic [BW-1:0] hist [HN];

  function automatic logic [BW-1:0] expv(int idx, int n);
    if (idx < n) return '0;
    return hist[idx - n];
  endfunction

  function automatic string tag_for(int idx, int n);
    string t;
    if (idx < n) t = after_mid ? "R7 zero after mid reset" : "R1 zero fill";
    else if (((idx - n) % 2) == 0) t = "R2 R3 R4 low half";
    else t = "R2 R6 high half";
    if (idx >= 2 * n) t = {t, " R5 wrap"};
    if (n == 6) t = {t, " R8"};
    return $sformatf("%s n=%0d m=%0d", t, n, idx);
  endfunction

  task automatic chk(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [BW-1:0] v);
    din = v;
    hist[m % HN] = v;
    @(negedge clk);
    chk(tag_for(m, 16), dout16, expv(m, 16));
    chk(tag_for(m, 4),  dout4,  expv(m, 4));
    chk(tag_for(m, 6),  dout6,  expv(m, 6));
    m++;
  endtask

  task automatic do_reset(int cycles);
    rst = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      din = BW'($urandom);
      @(negedge clk);
      chk("R7 reset state n=16", dout16, '0);
      chk("R7 reset state n=4",  dout4,  '0);
      chk("R7 reset state n=6",  dout6,  '0);
    end
    rst = 1'b0;
    m = 0;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);
    do_reset(3);
    for (int i = 0; i < 8; i++)  step('1);
    for (int i = 0; i < 8; i++)  step('0);
    for (int i = 0; i < 16; i++) step((i % 2 == 0) ? 8'hAA : 8'h55);
    for (int i = 0; i < 32; i++) step(BW'(i + 1));
    for (int i = 0; i < 250; i++) step(BW'($urandom));
    after_mid = 1'b1;
    do_reset(2);
    for (int i = 0; i < 6; i++)  step(BW'(8'hF0 + i));
    for (int i = 0; i < 250; i++) step(BW'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule